// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the device side of a network controller's transmit path. Software builds a ring of 16-byte descriptors in memory, hands each one to the device by setting its ownership bit, programs the ring base address and kicks a poll register. The engine then walks the ring. It reads each descriptor through a single word-wide memory port and fetches the referenced buffer a word at a time. It streams the buffer as bytes, marking the first and the last byte of the frame. It then rewrites the status word with ownership returned to software.

The engine moves from one descriptor to the next until it meets one it does not own. The ring length is never programmed. A marker bit in the last descriptor sends the engine back to the base. Completion, error and "nothing to send" events are collected in a write-one-to-clear interrupt status register. A command register enables the transmitter. Clearing it halts all memory and stream activity at once.

Top module: `txd_fetch_engine`

## Requirements
- R1: After reset, the interrupt status, the command register and both base words read as zero. `mem_req` and `tx_valid` are low.
- R2: The ring base low word is at byte offset 0x20 and always reads with bits 7:0 zero (256-byte alignment). The base high word is at 0x24. The command byte is at 0x37, where bit 2 is the transmit enable. The 16-bit interrupt status is at 0x3E. Writing ones to 0x3E clears those bits, and a set event in the same cycle wins over the clear.
- R3: Writing byte value 0x40 to offset 0x38 while enabled starts ring processing. Any other value, or a kick while disabled, has no effect.
- R4: Descriptor n sits at base + 16·n. Word 0 is status: bit 31 owned-by-device, bit 30 end-of-ring, bit 29 first segment, bit 28 last segment, bits 12:0 frame length. Word 2 is the word-aligned buffer address. Buffer words are sent least significant byte first.
- R5: A good descriptor yields exactly length bytes on the stream. `tx_first` marks the first byte and `tx_last` marks the last. Data and markers stay stable while `tx_ready` is low.
- R6: After a frame is sent, the status word is written back with bit 31 cleared and all other bits unchanged, and interrupt bit 2 (send done) is set.
- R7: After writeback the engine moves to the next index. It goes to index 0 instead when end-of-ring was set, and continues with that descriptor in the same run.
- R8: A fetched status with bit 31 clear sets interrupt bit 7 (no descriptor available). Nothing is written back and the engine idles until the next kick.
- R9: A owned descriptor with its first- or last-segment bit clear sends no bytes. It sets interrupt bit 3 (send error), is written back with bit 31 cleared, and the engine moves on.
- R10: Writing 0x00 to the command byte stops memory requests and the byte stream from the next cycle on. A frame in flight is abandoned.
- R11: Writing the base low word resets the descriptor index to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink accepts byte |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |

## Verification
On every cycle, the embedded properties check that the stream holds its byte under backpressure and never starts a frame while another is open. They also check that a disabled engine issues no memory request and starts no run, that a "no descriptor" event leaves the engine idle, that events reach the status register, and that end-of-ring returns the index to zero. The byte content, exact frame lengths, writeback values, ring order across wrap, error skipping and the abort during a frame can only be shown by the bench scenarios. Those scenarios sweep frame lengths 60 to 67 (every final-word fill), with and without a stalling sink.

// File: rtl/txd_pkg.sv
package txd_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_BASE_LO = 8'h20;
  localparam logic [7:0] OFS_BASE_HI = 8'h24;
  localparam logic [7:0] OFS_CMD     = 8'h37;
  localparam logic [7:0] OFS_POLL    = 8'h38;
  localparam logic [7:0] OFS_ISR     = 8'h3E;
  localparam logic [7:0] POLL_GO     = 8'h40;

  localparam int CMD_TXEN = 2;
  localparam int ISR_OK   = 2;
  localparam int ISR_ERR  = 3;
  localparam int ISR_UNAV = 7;

  // descriptor status bits
  localparam int ST_OWN = 31;
  localparam int ST_EOR = 30;
  localparam int ST_FS  = 29;
  localparam int ST_LS  = 28;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_STAT, SQ_BUFA, SQ_DREQ, SQ_DOUT, SQ_WBAK
  } sq_state_t;
endpackage

// File: rtl/txd_regs.sv
module txd_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              kick_take,
  input  logic              ev_ok,
  input  logic              ev_err,
  input  logic              ev_unav,
  output logic              tx_en,
  output logic [ADDR_W-1:0] ring_base,
  output logic              base_wr,
  output logic              kick_pend
);
  import txd_pkg::*;

  logic [31:0] base_lo_q, base_hi_q;
  logic        en_q, en_d;
  logic        pend_q, pend_d;
  logic [15:0] isr_q, isr_d;
  logic        wr_lo, wr_hi, wr_cmd, wr_poll, wr_isr;

  always_comb begin
    wr_lo   = reg_we && (reg_addr == OFS_BASE_LO);
    wr_hi   = reg_we && (reg_addr == OFS_BASE_HI);
    wr_cmd  = reg_we && (reg_addr == OFS_CMD);
    wr_poll = reg_we && (reg_addr == OFS_POLL);
    wr_isr  = reg_we && (reg_addr == OFS_ISR);

    en_d = wr_cmd ? reg_wdata[CMD_TXEN] : en_q;

    pend_d = pend_q;
    if (kick_take) pend_d = 1'b0;
    if (wr_poll && (reg_wdata[7:0] == POLL_GO) && en_q) pend_d = 1'b1;
    if (!en_d) pend_d = 1'b0;

    isr_d = isr_q;
    if (wr_isr) isr_d = isr_q & ~reg_wdata[15:0];
    if (ev_ok)   isr_d[ISR_OK]   = 1'b1;
    if (ev_err)  isr_d[ISR_ERR]  = 1'b1;
    if (ev_unav) isr_d[ISR_UNAV] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      isr_q     <= '0;
    end else begin
      if (wr_lo) base_lo_q <= {reg_wdata[31:8], 8'h00};
      if (wr_hi) base_hi_q <= reg_wdata;
      en_q   <= en_d;
      pend_q <= pend_d;
      isr_q  <= isr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_BASE_LO: reg_rdata = base_lo_q;
      OFS_BASE_HI: reg_rdata = base_hi_q;
      OFS_CMD:     reg_rdata = {29'd0, en_q, 2'b00};
      OFS_ISR:     reg_rdata = {16'd0, isr_q};
      default:     reg_rdata = '0;
    endcase
  end

  assign tx_en     = en_q;
  assign ring_base = base_lo_q[ADDR_W-1:0];
  assign base_wr   = wr_lo;
  assign kick_pend = pend_q;

  // R2
  isr_ok_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ok |=> isr_q[ISR_OK]);
  // R9
  isr_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> isr_q[ISR_ERR]);
  // R3
  no_kick_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !kick_pend);
endmodule

// File: rtl/txd_ser.sv
module txd_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        ld,
  input  logic [31:0] ld_word,
  input  logic [2:0]  ld_cnt,
  input  logic        ld_first,
  input  logic        ld_last,
  output logic        busy,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_first,
  output logic        tx_last
);
  logic [31:0] word_q, word_d;
  logic [2:0]  cnt_q, cnt_d;
  logic        first_q, first_d;
  logic        lastw_q, lastw_d;
  logic        take;

  assign tx_valid = (cnt_q != 3'd0);
  assign tx_data  = word_q[7:0];
  assign tx_first = first_q;
  assign tx_last  = lastw_q && (cnt_q == 3'd1);
  assign busy     = tx_valid;
  assign take     = tx_valid && tx_ready;

  always_comb begin
    word_d  = word_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    lastw_d = lastw_q;
    if (take) begin
      word_d  = word_q >> 8;
      cnt_d   = cnt_q - 3'd1;
      first_d = 1'b0;
    end
    if (ld) begin
      word_d  = ld_word;
      cnt_d   = ld_cnt;
      first_d = ld_first;
      lastw_d = ld_last;
    end
    if (flush) cnt_d = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      lastw_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      lastw_q <= lastw_d;
    end
  end

  // frame tracking for the checks below
  logic in_frm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                in_frm_q <= 1'b0;
    else if (flush)            in_frm_q <= 1'b0;
    else if (take && tx_last)  in_frm_q <= 1'b0;
    else if (take)             in_frm_q <= 1'b1;
  end

  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R5
  no_nested_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && in_frm_q) |-> !tx_first);
  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !tx_valid);
endmodule

// File: rtl/txd_seq.sv
module txd_seq #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              kick_pend,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              kick_take,
  output logic              ev_ok,
  output logic              ev_err,
  output logic              ev_unav,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              ser_ld,
  output logic [31:0]       ser_word,
  output logic [2:0]        ser_cnt,
  output logic              ser_first,
  output logic              ser_last,
  input  logic              ser_busy
);
  import txd_pkg::*;

  localparam int DESC_SH = 4;   // 16-byte descriptors

  sq_state_t         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [31:0]       stat_q, stat_d;
  logic [ADDR_W-1:0] bufa_q, bufa_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              firstw_q, firstw_d;
  logic              ok_q, ok_d;
  logic [ADDR_W-1:0] desc_addr;

  assign desc_addr = ring_base + ADDR_W'({idx_q, {DESC_SH{1'b0}}});

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    stat_d   = stat_q;
    bufa_d   = bufa_q;
    rem_d    = rem_q;
    firstw_d = firstw_q;
    ok_d     = ok_q;

    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = {1'b0, stat_q[30:0]};
    kick_take = 1'b0;
    ev_ok     = 1'b0;
    ev_err    = 1'b0;
    ev_unav   = 1'b0;
    ser_ld    = 1'b0;
    ser_word  = mem_rdata;
    ser_first = firstw_q;
    ser_last  = (rem_q <= LEN_W'(4));
    ser_cnt   = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];

    case (st_q)
      SQ_IDLE: begin
        if (kick_pend) begin
          kick_take = 1'b1;
          st_d      = SQ_STAT;
        end
      end
      SQ_STAT: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          stat_d = mem_rdata;
          if (!mem_rdata[ST_OWN]) begin
            ev_unav = 1'b1;
            st_d    = SQ_IDLE;
          end else if (!(mem_rdata[ST_FS] && mem_rdata[ST_LS])) begin
            ok_d = 1'b0;
            st_d = SQ_WBAK;
          end else begin
            st_d = SQ_BUFA;
          end
        end
      end
      SQ_BUFA: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + ADDR_W'(8);
        if (mem_ack) begin
          bufa_d   = mem_rdata[ADDR_W-1:0];
          rem_d    = stat_q[LEN_W-1:0];
          firstw_d = 1'b1;
          ok_d     = 1'b1;
          st_d     = (stat_q[LEN_W-1:0] == '0) ? SQ_WBAK : SQ_DREQ;
        end
      end
      SQ_DREQ: begin
        mem_req  = 1'b1;
        mem_addr = bufa_q;
        if (mem_ack) begin
          ser_ld   = 1'b1;
          bufa_d   = bufa_q + ADDR_W'(4);
          rem_d    = rem_q - LEN_W'(ser_cnt);
          firstw_d = 1'b0;
          st_d     = SQ_DOUT;
        end
      end
      SQ_DOUT: begin
        if (!ser_busy) st_d = (rem_q == '0) ? SQ_WBAK : SQ_DREQ;
      end
      SQ_WBAK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          ev_ok  = ok_q;
          ev_err = !ok_q;
          idx_d  = stat_q[ST_EOR] ? '0 : idx_q + IDX_W'(1);
          st_d   = SQ_STAT;
        end
      end
      default: st_d = SQ_IDLE;
    endcase

    if (base_wr) idx_d = '0;
    if (!tx_en)  st_d  = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      idx_q    <= '0;
      stat_q   <= '0;
      bufa_q   <= '0;
      rem_q    <= '0;
      firstw_q <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      stat_q   <= stat_d;
      bufa_q   <= bufa_d;
      rem_q    <= rem_d;
      firstw_q <= firstw_d;
      ok_q     <= ok_d;
    end
  end

  // R10
  halt_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !mem_req);
  // R8
  unav_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unav |=> (!mem_req && !kick_take));
  // R7
  eor_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_ok || ev_err) && stat_q[ST_EOR]) |=> (idx_q == '0));
  // R6
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_ok, ev_err, ev_unav}) <= 1);
endmodule

// File: rtl/txd_fetch_engine.sv
module txd_fetch_engine #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_first,
  output logic              tx_last
);
  logic              tx_en, base_wr, kick_pend, kick_take;
  logic              ev_ok, ev_err, ev_unav;
  logic [ADDR_W-1:0] ring_base;
  logic              ser_ld, ser_first, ser_last, ser_busy;
  logic [31:0]       ser_word;
  logic [2:0]        ser_cnt;

  txd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .kick_take(kick_take), .ev_ok(ev_ok), .ev_err(ev_err), .ev_unav(ev_unav),
    .tx_en(tx_en), .ring_base(ring_base), .base_wr(base_wr), .kick_pend(kick_pend)
  );

  txd_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .kick_pend(kick_pend), .base_wr(base_wr), .ring_base(ring_base),
    .kick_take(kick_take), .ev_ok(ev_ok), .ev_err(ev_err), .ev_unav(ev_unav),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ser_ld(ser_ld), .ser_word(ser_word), .ser_cnt(ser_cnt),
    .ser_first(ser_first), .ser_last(ser_last), .ser_busy(ser_busy)
  );

  txd_ser u_ser (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en),
    .ld(ser_ld), .ld_word(ser_word), .ld_cnt(ser_cnt),
    .ld_first(ser_first), .ld_last(ser_last), .busy(ser_busy),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last)
  );
endmodule

// File: tb/txd_fetch_engine_tb.sv
module txd_fetch_engine_tb;
  localparam int BASE  = 32'h100;
  localparam int BUFB  = 32'h800;
  localparam int NDESC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'h0;
  logic        tx_valid, tx_first, tx_last;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;

  always #5 clk = ~clk;

  txd_fetch_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last)
  );

  logic [31:0] mem [0:1023];
  logic [7:0]  cap_d [0:4095];
  logic        cap_f [0:4095];
  logic        cap_l [0:4095];
  int cap_n = 0, act_cnt = 0, rdy_ctr = 0, n_cmp = 0, n_bad = 0;
  bit rdy_slow = 1'b0, done = 1'b0;
  int exp_d [0:63];
  int exp_len [0:63];
  int exp_seed [0:63];
  int exp_n = 0;
  logic [31:0] posted [0:NDESC-1];

  // memory and stream sink model, acting between clock edges
  always @(negedge clk) begin
    rdy_ctr++;
    tx_ready = rdy_slow ? ((rdy_ctr % 3) != 0) : 1'b1;
    if (tx_valid && tx_ready && cap_n < 4096) begin
      cap_d[cap_n] = tx_data; cap_f[cap_n] = tx_first; cap_l[cap_n] = tx_last;
      cap_n++;
    end
    if (mem_req || tx_valid) act_cnt++;
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
      else        mem_rdata = mem[mem_addr[11:2]];
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(int d, int k, int s);
    return 8'((d * 41 + k * 7 + s * 13) & 255);
  endfunction

  function automatic int dw(int d);
    return BASE / 4 + 4 * d;
  endfunction

  task automatic post(int d, int len, int s, bit fs, bit ls);
    logic [31:0] st;
    st = {1'b1, (d == NDESC - 1), fs, ls, 15'd0, 13'(len)};
    posted[d] = st;
    mem[dw(d)]     = st;
    mem[dw(d) + 1] = 32'hA5A5_0000 | d;
    mem[dw(d) + 2] = BUFB + d * 128;
    mem[dw(d) + 3] = 32'h0;
    for (int w = 0; w < 32; w++)
      mem[(BUFB + d * 128) / 4 + w] = {pat(d, 4*w+3, s), pat(d, 4*w+2, s), pat(d, 4*w+1, s), pat(d, 4*w, s)};
    if (fs && ls) begin
      exp_d[exp_n] = d; exp_len[exp_n] = len; exp_seed[exp_n] = s; exp_n++;
    end
  endtask

  task automatic clear_exp();
    exp_n = 0; cap_n = 0;
  endtask

  task automatic wait_unav(input string req);
    logic [31:0] v;
    int lim = 0;
    v = 0;
    while (!v[7] && lim < 20000) begin rd(8'h3E, v); lim++; end
    chk(req, "no-descriptor event reached", v[7], 1);
  endtask

  task automatic check_frames(input string req);
    int pos = 0;
    for (int f = 0; f < exp_n; f++) begin
      int bad = 0;
      for (int k = 0; k < exp_len[f]; k++) begin
        logic [7:0] e;
        e = pat(exp_d[f], k, exp_seed[f]);
        if (pos + k >= cap_n) bad++;
        else if (cap_d[pos+k] !== e || cap_f[pos+k] !== (k == 0) ||
                 cap_l[pos+k] !== (k == exp_len[f] - 1)) bad++;
      end
      chk(req, $sformatf("frame %0d (desc %0d) bad bytes", f, exp_d[f]), bad, 0);
      pos += exp_len[f];
    end
    chk(req, "total streamed bytes", cap_n, pos);
  endtask

  task automatic wb_check(input string req, int d);
    chk(req, $sformatf("writeback desc %0d", d), mem[dw(d)], posted[d] & 32'h7FFF_FFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "tx_valid in reset", tx_valid, 0);
    chk("R1", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    rd(8'h3E, v); chk("R1", "isr after reset", v, 0);
    rd(8'h37, v); chk("R1", "cmd after reset", v, 0);
    rd(8'h20, v); chk("R1", "base lo after reset", v, 0);

    // R2 register map
    wr(8'h20, 32'h0000_01FF); rd(8'h20, v); chk("R2", "base lo aligned", v, 32'h100);
    wr(8'h24, 32'h1234_5678); rd(8'h24, v); chk("R2", "base hi", v, 32'h1234_5678);
    wr(8'h37, 32'h04);        rd(8'h37, v); chk("R2", "cmd enable", v, 32'h04);

    // R8 empty ring
    clear_exp();
    wr(8'h38, 32'h40);
    wait_unav("R8");
    rd(8'h3E, v); chk("R8", "isr only unavailable", v, 32'h80);
    chk("R8", "no bytes", cap_n, 0);
    chk("R8", "no writeback", mem[dw(0)], 0);
    wr(8'h3E, 32'h80); rd(8'h3E, v); chk("R2", "isr write-one clear", v, 0);

    // R3 wrong poll value
    act_cnt = 0;
    wr(8'h38, 32'h41);
    repeat (40) @(negedge clk);
    chk("R3", "activity after non-0x40 poll", act_cnt, 0);
    rd(8'h3E, v); chk("R3", "isr after non-0x40 poll", v, 0);

    // R4 R5 R6 R7 sweep of lengths 60..67 with both sink behaviours
    for (int r = 0; r < 6; r++) begin
      rdy_slow = r[0];
      clear_exp();
      for (int d = 0; d < NDESC; d++) post(d, 60 + ((r * 4 + d) % 8), r, 1'b1, 1'b1);
      wr(8'h38, 32'h40);
      wait_unav("R7");
      check_frames("R5");
      for (int d = 0; d < NDESC; d++) wb_check("R6", d);
      rd(8'h3E, v); chk("R6", "isr done+unavail", v, 32'h84);
      wr(8'h3E, 32'hFFFF);
    end

    // R7 wrap in mid-run
    clear_exp();
    post(0, 61, 7, 1, 1); post(1, 62, 7, 1, 1);
    wr(8'h38, 32'h40); wait_unav("R7");
    post(2, 63, 8, 1, 1); post(3, 64, 8, 1, 1); post(0, 65, 8, 1, 1);
    wr(8'h3E, 32'hFFFF);
    wr(8'h38, 32'h40); wait_unav("R7");
    check_frames("R7");
    wb_check("R7", 0);
    wr(8'h3E, 32'hFFFF);

    // R9 segment errors, R11 index reset by base write
    clear_exp();
    wr(8'h20, BASE);
    post(0, 60, 9, 1, 0); post(1, 66, 9, 1, 1); post(2, 60, 9, 0, 1);
    wr(8'h38, 32'h40); wait_unav("R9");
    check_frames("R11");
    wb_check("R9", 0); wb_check("R9", 2); wb_check("R9", 1);
    rd(8'h3E, v); chk("R9", "isr done+error+unavail", v, 32'h8C);
    wr(8'h3E, 32'hFFFF);

    // R10 R3 kick while disabled
    wr(8'h37, 32'h00);
    wr(8'h20, BASE);
    clear_exp();
    post(0, 60, 10, 1, 1);
    act_cnt = 0;
    wr(8'h38, 32'h40);
    repeat (40) @(negedge clk);
    chk("R10", "activity while disabled", act_cnt, 0);
    rd(8'h3E, v); chk("R3", "isr after disabled kick", v, 0);
    chk("R10", "descriptor still owned", mem[dw(0)][31], 1);

    // R10 abort during a frame
    rdy_slow = 1'b1;
    wr(8'h37, 32'h04);
    wr(8'h38, 32'h40);
    begin
      int lim = 0;
      while (cap_n < 5 && lim < 2000) begin @(negedge clk); lim++; end
    end
    wr(8'h37, 32'h00);
    @(negedge clk);
    act_cnt = 0;
    repeat (30) @(negedge clk);
    chk("R10", "activity after stop", act_cnt, 0);
    chk("R10", "frame abandoned", (cap_n < 60), 1);

    // R11 restart from index 0 after base write
    wr(8'h20, BASE);
    wr(8'h3E, 32'hFFFF);
    wr(8'h37, 32'h04);
    clear_exp();
    for (int d = 0; d < NDESC; d++) post(d, 67 - d, 11, 1, 1);
    wr(8'h38, 32'h40); wait_unav("R11");
    check_frames("R11");
    rd(8'h3E, v); chk("R6", "isr after restart", v, 32'h84);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule